// File: doc/BRIEF.md
# Paged Data Pointer Register File

This block holds a data pointer built from three byte registers: a page byte, a high byte and a low byte. Together they form a 24-bit address for code and data memory accesses. The processor can read or write any one of the three bytes through a byte-wide port. It can also load the high and low bytes together as one 16-bit value, and it can issue an increment command that counts the whole pointer as a single 24-bit value.

The block keeps two copies of the pointer. A select input picks the active copy. Every write, every read and every increment acts on the active copy only. The 24-bit address of the active copy is always present on the address output.

Register address decoding on a wider special-register bus lies outside this block, and so does the memory access itself.

Top module: `pgptr_top`

## Requirements
- R1: After reset, every byte of both pointer copies reads 0x00.
- R2: A byte write with `byteSel` = 0, 1 or 2 loads the low, high or page byte of the active copy on the next clock edge. The other two bytes keep their values.
- R3: A byte write with `byteSel` = 3 changes no byte of either copy. In that cycle a pair write or an increment still takes effect as though no byte write were present.
- R4: `rdData` shows, without delay, the low, high or page byte of the active copy when `rdSel` is 0, 1 or 2. When `rdSel` is 3, `rdData` is 0x00.
- R5: A 16-bit pair write loads `pairWrData[15:8]` into the high byte and `pairWrData[7:0]` into the low byte. The page byte does not change.
- R6: An increment adds one to the 24-bit value {page, high, low}. A carry out of the low 16 bits passes into the page byte.
- R7: An increment from 0xFFFFFF gives 0x000000.
- R8: Writes and increments change only the copy chosen by `selCopy`. The other copy keeps its value.
- R9: Only one operation takes effect in a cycle. A valid byte write comes first, then a pair write, then an increment; each lower-priority command in the same cycle is dropped.
- R10: `addrOut` always equals {page, high, low} of the copy chosen by `selCopy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selCopy | input | 1 | Active pointer copy |
| byteWrEn | input | 1 | Byte write strobe |
| byteSel | input | 2 | Byte to write: 0 low, 1 high, 2 page, 3 none |
| byteWrData | input | 8 | Byte write data |
| pairWrEn | input | 1 | 16-bit high/low pair write strobe |
| pairWrData | input | 16 | Pair write data, high byte in bits 15:8 |
| incEn | input | 1 | Increment command |
| rdSel | input | 2 | Byte to read: 0 low, 1 high, 2 page, 3 zero |
| rdData | output | 8 | Selected byte of the active copy |
| addrOut | output | 24 | Full address of the active copy |

## Verification
Random stimulus mixes byte writes, pair writes, increments and copy switches, and changes the read select on every cycle. This tells apart a fault in the byte that gets written, a fault in the copy that gets targeted, and a fault in the read mux. Directed cases cover the following:
- an increment from 0x00FFFF, which shows whether the carry reaches the page byte;
- an increment from 0xFFFFFF, which shows the wrap to zero;
- a pair write over a nonzero page byte, which shows the page byte is preserved;
- commands that collide in the same cycle, which expose the priority order;
- a write with byte select 3, which must change nothing.

// File: rtl/pgptr_pkg.sv
package pgptr_pkg;

  // One-cycle command strobes passed from control to datapath.
  // At most one of these is set in any cycle.
  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wrPg;
    logic wrPair;
    logic inc;
  } ptrStrobe_t;

  // Byte position codes shared by the write select and the read select.
  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_PG   = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

endpackage

// File: rtl/pgptr_ctrl.sv
module pgptr_ctrl
  import pgptr_pkg::*;
#(
  parameter int SEL_W = 1
) (
  input  logic             byteWrEn,
  input  logic [1:0]       byteSel,
  input  logic             pairWrEn,
  input  logic             incEn,
  input  logic [SEL_W-1:0] selCopy,
  output ptrStrobe_t       strobe,
  output logic [SEL_W-1:0] tgtCopy
);

  logic byteHit;

  // A byte write with select code 3 does not count as a write.
  assign byteHit = byteWrEn && (byteSel != SEL_NONE);

  // Priority: byte write first, then pair write, then increment.
  always_comb begin
    strobe        = '0;
    strobe.wrLo   = byteHit && (byteSel == SEL_LO);
    strobe.wrHi   = byteHit && (byteSel == SEL_HI);
    strobe.wrPg   = byteHit && (byteSel == SEL_PG);
    strobe.wrPair = pairWrEn && !byteHit;
    strobe.inc    = incEn && !byteHit && !pairWrEn;
  end

  assign tgtCopy = selCopy;

endmodule

// File: rtl/pgptr_dpath.sv
module pgptr_dpath
  import pgptr_pkg::*;
#(
  parameter int NUM_COPIES = 2,
  parameter int BYTE_W     = 8,
  parameter int SEL_W      = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ptrStrobe_t          strobe,
  input  logic [SEL_W-1:0]    tgtCopy,
  input  logic [BYTE_W-1:0]   byteWrData,
  input  logic [2*BYTE_W-1:0] pairWrData,
  input  logic [SEL_W-1:0]    selCopy,
  input  logic [1:0]          rdSel,
  output logic [BYTE_W-1:0]   rdData,
  output logic [3*BYTE_W-1:0] addrOut
);

  localparam int ADDR_W = 3 * BYTE_W;
  localparam int PAIR_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] ptrAll [NUM_COPIES];

  // One register group per copy: {page, high, low}.
  for (genvar c = 0; c < NUM_COPIES; c++) begin : gen_copy
    logic [ADDR_W-1:0] ptrQ;
    logic              hitCopy;

    assign hitCopy = (tgtCopy == SEL_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ <= '0;
      end else if (hitCopy) begin
        if (strobe.wrLo)   ptrQ[BYTE_W-1:0]        <= byteWrData;
        if (strobe.wrHi)   ptrQ[PAIR_W-1:BYTE_W]   <= byteWrData;
        if (strobe.wrPg)   ptrQ[ADDR_W-1:PAIR_W]   <= byteWrData;
        if (strobe.wrPair) ptrQ[PAIR_W-1:0]        <= pairWrData;
        if (strobe.inc)    ptrQ                    <= ptrQ + ONE;
      end
    end

    assign ptrAll[c] = ptrQ;
  end

  logic [ADDR_W-1:0] activePtr;
  assign activePtr = ptrAll[selCopy];
  assign addrOut   = activePtr;

  always_comb begin
    case (rdSel)
      SEL_LO:  rdData = activePtr[BYTE_W-1:0];
      SEL_HI:  rdData = activePtr[PAIR_W-1:BYTE_W];
      SEL_PG:  rdData = activePtr[ADDR_W-1:PAIR_W];
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/pgptr_top.sv
module pgptr_top
  import pgptr_pkg::*;
#(
  parameter int NUM_COPIES = 2,
  parameter int BYTE_W     = 8,
  localparam int SEL_W     = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEL_W-1:0]    selCopy,
  input  logic                byteWrEn,
  input  logic [1:0]          byteSel,
  input  logic [BYTE_W-1:0]   byteWrData,
  input  logic                pairWrEn,
  input  logic [2*BYTE_W-1:0] pairWrData,
  input  logic                incEn,
  input  logic [1:0]          rdSel,
  output logic [BYTE_W-1:0]   rdData,
  output logic [3*BYTE_W-1:0] addrOut
);

  ptrStrobe_t       strobe;
  logic [SEL_W-1:0] tgtCopy;

  pgptr_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .byteWrEn (byteWrEn),
    .byteSel  (byteSel),
    .pairWrEn (pairWrEn),
    .incEn    (incEn),
    .selCopy  (selCopy),
    .strobe   (strobe),
    .tgtCopy  (tgtCopy)
  );

  pgptr_dpath #(
    .NUM_COPIES (NUM_COPIES),
    .BYTE_W     (BYTE_W),
    .SEL_W      (SEL_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .tgtCopy    (tgtCopy),
    .byteWrData (byteWrData),
    .pairWrData (pairWrData),
    .selCopy    (selCopy),
    .rdSel      (rdSel),
    .rdData     (rdData),
    .addrOut    (addrOut)
  );

endmodule

// File: rtl/pgptr_chk.sv
module pgptr_chk #(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 1
) (
  input logic                clk,
  input logic                rstN,
  input logic [SEL_W-1:0]    selCopy,
  input logic                byteWrEn,
  input logic [1:0]          byteSel,
  input logic [BYTE_W-1:0]   byteWrData,
  input logic                pairWrEn,
  input logic [2*BYTE_W-1:0] pairWrData,
  input logic                incEn,
  input logic [1:0]          rdSel,
  input logic [BYTE_W-1:0]   rdData,
  input logic [3*BYTE_W-1:0] addrOut
);

  localparam int ADDR_W = 3 * BYTE_W;
  localparam int PAIR_W = 2 * BYTE_W;

  logic validByte;
  assign validByte = byteWrEn && (byteSel != 2'd3);

  // R2
  low_byte_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validByte && byteSel == 2'd0) |=> (selCopy != $past(selCopy)) ||
      (addrOut[BYTE_W-1:0] == $past(byteWrData) &&
       addrOut[ADDR_W-1:BYTE_W] == $past(addrOut[ADDR_W-1:BYTE_W])));

  // R5
  pair_keeps_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pairWrEn && !validByte) |=> (selCopy != $past(selCopy)) ||
      (addrOut == {$past(addrOut[ADDR_W-1:PAIR_W]), $past(pairWrData)}));

  // R6
  inc_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incEn && !validByte && !pairWrEn) |=> (selCopy != $past(selCopy)) ||
      (addrOut == $past(addrOut) + {{(ADDR_W-1){1'b0}}, 1'b1}));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!validByte && !pairWrEn && !incEn) |=> (selCopy != $past(selCopy)) ||
      (addrOut == $past(addrOut)));

  // R4
  read_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == 2'd2) |-> (rdData == addrOut[ADDR_W-1:PAIR_W]));

  // R4
  read_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == 2'd3) |-> (rdData == '0));

endmodule

bind pgptr_top pgptr_chk #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/pgptr_top_tb.sv
`timescale 1ns/1ps
module pgptr_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selCopy = 1'b0;
  logic        byteWrEn = 1'b0;
  logic [1:0]  byteSel = 2'd0;
  logic [7:0]  byteWrData = 8'h00;
  logic        pairWrEn = 1'b0;
  logic [15:0] pairWrData = 16'h0000;
  logic        incEn = 1'b0;
  logic [1:0]  rdSel = 2'd0;
  logic [7:0]  rdData;
  logic [23:0] addrOut;

  int checks = 0;
  int errors = 0;
  logic [23:0] model [2];

  always #2.5 clk = ~clk;

  pgptr_top u_dut (
    .clk(clk), .rstN(rstN), .selCopy(selCopy), .byteWrEn(byteWrEn),
    .byteSel(byteSel), .byteWrData(byteWrData), .pairWrEn(pairWrEn),
    .pairWrData(pairWrData), .incEn(incEn), .rdSel(rdSel),
    .rdData(rdData), .addrOut(addrOut)
  );

  // Next pointer value from the requirements (priority byte > pair > inc).
  function automatic logic [23:0] nextVal(logic [23:0] cur, logic bwe, logic [1:0] bsel,
                                          logic [7:0] bdat, logic pwe, logic [15:0] pdat,
                                          logic inc);
    logic [23:0] n = cur;
    if (bwe && bsel != 2'd3) begin
      case (bsel)
        2'd0: n[7:0]   = bdat;
        2'd1: n[15:8]  = bdat;
        default: n[23:16] = bdat;
      endcase
    end else if (pwe) n[15:0] = pdat;
    else if (inc) n = cur + 24'd1;
    return n;
  endfunction

  function automatic logic [7:0] readByte(logic [23:0] v, logic [1:0] s);
    case (s)
      2'd0: return v[7:0];
      2'd1: return v[15:8];
      2'd2: return v[23:16];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %06h expected %06h", req, act, exp);
    end
  endtask

  // Apply one cycle of commands, then check address and read data.
  task automatic step(string req, logic sel, logic bwe, logic [1:0] bsel, logic [7:0] bdat,
                      logic pwe, logic [15:0] pdat, logic inc, logic [1:0] rs);
    @(negedge clk);
    selCopy = sel; byteWrEn = bwe; byteSel = bsel; byteWrData = bdat;
    pairWrEn = pwe; pairWrData = pdat; incEn = inc; rdSel = rs;
    model[sel] = nextVal(model[sel], bwe, bsel, bdat, pwe, pdat, inc);
    @(posedge clk);
    #1;
    chk(req, addrOut, model[sel]);
    chk(req, {16'h0, rdData}, {16'h0, readByte(model[sel], rs)});
  endtask

  task automatic peek(string req, logic sel, logic [1:0] rs);
    step(req, sel, 1'b0, 2'd0, 8'h00, 1'b0, 16'h0, 1'b0, rs);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model[0] = 24'h0; model[1] = 24'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state of both copies, each byte
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 4; s++) peek("R1", c[0], s[1:0]);

    // R2: byte writes to low, high, page of copy 0
    step("R2", 1'b0, 1'b1, 2'd0, 8'h11, 1'b0, 16'h0, 1'b0, 2'd0);
    step("R2", 1'b0, 1'b1, 2'd1, 8'h22, 1'b0, 16'h0, 1'b0, 2'd1);
    step("R2", 1'b0, 1'b1, 2'd2, 8'h33, 1'b0, 16'h0, 1'b0, 2'd2);
    // R8: copy 1 untouched by copy 0 writes
    peek("R8", 1'b1, 2'd2);
    chk("R8", addrOut, 24'h000000);
    peek("R10", 1'b0, 2'd3);
    chk("R10", addrOut, 24'h332211);
    // R3: select 3 writes nothing, but an increment in the same cycle proceeds
    step("R3", 1'b0, 1'b1, 2'd3, 8'hAA, 1'b0, 16'h0, 1'b0, 2'd0);
    chk("R3", addrOut, 24'h332211);
    step("R3", 1'b0, 1'b1, 2'd3, 8'hAA, 1'b0, 16'h0, 1'b1, 2'd0);
    chk("R3", addrOut, 24'h332212);
    // R5: pair write keeps the page byte
    step("R5", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 16'hFFFF, 1'b0, 2'd2);
    chk("R5", addrOut, 24'h33FFFF);
    // R6: carry into page
    step("R6", 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 16'h0, 1'b1, 2'd2);
    chk("R6", addrOut, 24'h340000);
    // R7: wrap from all ones on copy 1
    step("R7", 1'b1, 1'b1, 2'd2, 8'hFF, 1'b0, 16'h0, 1'b0, 2'd2);
    step("R7", 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 16'hFFFF, 1'b0, 2'd0);
    step("R7", 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 16'h0, 1'b1, 2'd1);
    chk("R7", addrOut, 24'h000000);
    peek("R8", 1'b0, 2'd0);
    chk("R8", addrOut, 24'h340000);
    // R9: byte write beats pair write and increment; pair beats increment
    step("R9", 1'b0, 1'b1, 2'd1, 8'h5A, 1'b1, 16'h1234, 1'b1, 2'd1);
    chk("R9", addrOut, 24'h345A00);
    step("R9", 1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 16'h1234, 1'b1, 2'd0);
    chk("R9", addrOut, 24'h341234);

    // Random mix (R2, R4, R5, R6, R8, R9, R10 compared against the model)
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      step("R10", r[0], r[2:1] == 2'd0, r[4:3], r[12:5], r[14:13] == 2'd0,
           r[30:15], r[31], r[16:15]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule